// File: doc/BRIEF.md
# ATA Status Poll Engine

This block runs the status wait that a host performs on a disk channel right after a command has gone out. Once started, it first reads the alternate status register a fixed number of times, which only serves to let the device settle. It then reads the main status register over and over until the busy bit reads low. All register reads go through a request/acknowledge port with a single request in flight.

When the busy bit clears, the engine reports a 2-bit result code together with a one-cycle completion pulse. With classification enabled, the final status byte is sorted by priority into error, device fault, missing data request, or clean. With classification disabled, a clear busy bit alone yields the clean code. An optional cycle limit ends a busy wait that runs too long and raises a separate timeout flag.

Top module: `ata_status_poller`

## Requirements
- R1: After a start, exactly four reads with `rd_sel_o` = 0 (alternate status) are completed before the first read with `rd_sel_o` = 1 (status).
- R2: Status reads repeat while bit 7 (busy) of the returned byte is 1. The run completes on the first status read whose bit 7 is 0, so the number of status reads is one more than the number of busy responses.
- R3: With `classify_i` = 1 at start, a final status byte with bit 0 (error) set gives result 2, whatever the other bits hold.
- R4: With classification enabled and bit 0 clear, bit 5 (device fault) set gives result 1, whatever bit 3 holds.
- R5: With classification enabled and bits 0 and 5 clear, result is 3 when bit 3 (data request) is 0 and 0 when bit 3 is 1.
- R6: With `classify_i` = 0 at start, result is 0 whatever the final status byte holds.
- R7: Only one read is outstanding. `rd_req_o` stays high until `rd_ack_i` is seen and drops in the cycle after the acknowledge. The only other way it drops is a timeout abort.
- R8: With `timeout_lim_i` nonzero, a status phase that lasts `timeout_lim_i` cycles without completing ends the run with `timeout_o` = 1 and result 0. A value of 0 disables the limit. A normal completion clears `timeout_o`.
- R9: `start_i` is ignored while `busy_o` is 1. The mode that was latched at start is kept, and no extra settle reads or completions occur.
- R10: `done_o` is high for exactly one cycle per run. `result_o` and `timeout_o` change only with `done_o` and hold their values between runs.
- R11: After reset, `busy_o`, `done_o`, `rd_req_o`, `timeout_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a poll run (sampled only when idle) |
| classify_i | input | 1 | 1: classify final status; 0: busy wait only |
| timeout_lim_i | input | TMO_W | Status-phase cycle limit, 0 = no limit |
| rd_req_o | output | 1 | Register read request, held until acknowledged |
| rd_sel_o | output | 1 | Register select: 0 alternate status, 1 status |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | DW | Read response byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Result code |
| timeout_o | output | 1 | Last run ended by timeout |

## Verification
A wrong sequencer state appears on the read port within one transaction. A miscount in the settle counter shows up as the wrong number of alternate-status reads before the first status read. A stuck request shows up as a second request that starts without a response in between. Errors in the classifier or in the latched mode appear on `result_o` in the same cycle as `done_o`. Each status pattern is chosen so that only one priority level can explain the code seen. A timer fault shows either as a timeout during a run that should have finished, or as a run that never ends.

// File: rtl/ata_poll_pkg.sv
package ata_poll_pkg;

  // Status byte bit positions decoded by the classifier
  localparam int STAT_ERR_BIT = 0;
  localparam int STAT_DRQ_BIT = 3;
  localparam int STAT_DF_BIT  = 5;
  localparam int STAT_BSY_BIT = 7;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_FAULT  = 2'd1,
    RES_ERROR  = 2'd2,
    RES_NO_DRQ = 2'd3
  } poll_res_e;

  typedef enum logic {
    SEL_ALT  = 1'b0,
    SEL_STAT = 1'b1
  } rd_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_POLL   = 2'd2
  } poll_st_e;

endpackage

// File: rtl/ata_poll_classify.sv
module ata_poll_classify
  import ata_poll_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] status_i,
  output logic [1:0]    code_o
);

  // Priority: error first, then fault, then missing data request
  always_comb begin
    if (status_i[STAT_ERR_BIT])
      code_o = RES_ERROR;
    else if (status_i[STAT_DF_BIT])
      code_o = RES_FAULT;
    else if (!status_i[STAT_DRQ_BIT])
      code_o = RES_NO_DRQ;
    else
      code_o = RES_OK;
  end

endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)
      cnt_q <= '0;
    else if (cnt_q != limit_i)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && (limit_i != '0) && (cnt_q == limit_i);

endmodule

// File: rtl/ata_poll_seq.sv
module ata_poll_seq
  import ata_poll_pkg::*;
#(
  parameter int DW           = 8,
  parameter int SETTLE_READS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          classify_i,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [1:0]    cls_code_i,
  input  logic          expire_i,
  output logic          rd_req_o,
  output logic          rd_sel_o,
  output logic          poll_phase_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          timeout_o
);

  localparam int SCW = $clog2(SETTLE_READS + 1);
  localparam logic [SCW-1:0] SETTLE_LAST = SCW'(SETTLE_READS - 1);

  poll_st_e       st_q;
  logic           req_q;
  rd_sel_e        sel_q;
  logic [SCW-1:0] settle_q;
  logic           cls_q;
  logic           done_q;
  logic [1:0]     res_q;
  logic           to_q;
  logic           got_rsp;

  assign got_rsp = req_q && rd_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      req_q    <= 1'b0;
      sel_q    <= SEL_ALT;
      settle_q <= '0;
      cls_q    <= 1'b0;
      done_q   <= 1'b0;
      res_q    <= RES_OK;
      to_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            cls_q    <= classify_i;
            settle_q <= '0;
            sel_q    <= SEL_ALT;
            req_q    <= 1'b1;
            st_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (got_rsp) begin
            req_q <= 1'b0;
            if (settle_q == SETTLE_LAST) begin
              sel_q <= SEL_STAT;
              st_q  <= ST_POLL;
            end else begin
              settle_q <= settle_q + 1'b1;
            end
          end else if (!req_q) begin
            req_q <= 1'b1;
          end
        end
        ST_POLL: begin
          if (got_rsp) begin
            req_q <= 1'b0;
            if (!rd_data_i[STAT_BSY_BIT]) begin
              done_q <= 1'b1;
              res_q  <= cls_q ? cls_code_i : RES_OK;
              to_q   <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end else if (expire_i) begin
            req_q  <= 1'b0;
            done_q <= 1'b1;
            res_q  <= RES_OK;
            to_q   <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (!req_q) begin
            req_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_o     = req_q;
  assign rd_sel_o     = sel_q;
  assign poll_phase_o = (st_q == ST_POLL);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign timeout_o    = to_q;

endmodule

// File: rtl/ata_status_poller.sv
module ata_status_poller #(
  parameter int DW           = 8,
  parameter int SETTLE_READS = 4,
  parameter int TMO_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             classify_i,
  input  logic [TMO_W-1:0] timeout_lim_i,
  output logic             rd_req_o,
  output logic             rd_sel_o,
  input  logic             rd_ack_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  output logic             timeout_o
);

  logic [1:0] cls_code;
  logic       poll_phase;
  logic       expire;

  ata_poll_classify #(.DW(DW)) i_classify (
    .status_i (rd_data_i),
    .code_o   (cls_code)
  );

  ata_poll_timer #(.TMO_W(TMO_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .en_i     (poll_phase),
    .limit_i  (timeout_lim_i),
    .expire_o (expire)
  );

  ata_poll_seq #(.DW(DW), .SETTLE_READS(SETTLE_READS)) i_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .classify_i   (classify_i),
    .rd_ack_i     (rd_ack_i),
    .rd_data_i    (rd_data_i),
    .cls_code_i   (cls_code),
    .expire_i     (expire),
    .rd_req_o     (rd_req_o),
    .rd_sel_o     (rd_sel_o),
    .poll_phase_o (poll_phase),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .timeout_o    (timeout_o)
  );

endmodule

// File: rtl/ata_status_poller_chk.sv
module ata_status_poller_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_req_o,
  input logic       rd_ack_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o,
  input logic       timeout_o
);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o || (done_o && timeout_o)));

  // R7
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_ack_i) |=> !rd_req_o);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(result_o) && $stable(timeout_o)));

  // R8
  timeout_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && timeout_o) |-> (result_o == 2'd0));

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));

endmodule

bind ata_status_poller ata_status_poller_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o),
  .timeout_o (timeout_o)
);

// File: tb/test_ata_status_poller.sv
module test_ata_status_poller;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        classify_i = 1'b0;
  logic [15:0] timeout_lim_i = '0;
  logic        rd_req_o, rd_sel_o;
  logic        rd_ack_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        busy_o, done_o, timeout_o;
  logic [1:0]  result_o;

  always #4 clk = ~clk;

  ata_status_poller i_ata_status_poller (
    .clk(clk), .rst(rst), .start_i(start_i), .classify_i(classify_i),
    .timeout_lim_i(timeout_lim_i), .rd_req_o(rd_req_o), .rd_sel_o(rd_sel_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .timeout_o(timeout_o)
  );

  int n_chk = 0, n_bad = 0;
  int cycles = 0;

  // device model state
  int       lat = 0, wcnt = 0;
  int       bsy_left = 0;
  logic [7:0] fin_stat = '0;
  int       alt_before = 0, stat_reads = 0;
  bit       seen_stat = 0;

  always @(negedge clk) begin
    if (rst) begin
      rd_ack_i = 1'b0; wcnt = 0;
    end else if (rd_ack_i) begin
      rd_ack_i = 1'b0;
    end else if (rd_req_o) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        rd_ack_i = 1'b1;
        if (!rd_sel_o) begin
          rd_data_i = 8'h7F;
          if (!seen_stat) alt_before++;
        end else begin
          seen_stat = 1;
          stat_reads++;
          if (bsy_left > 0) begin bsy_left--; rd_data_i = 8'h80; end
          else rd_data_i = fin_stat;
        end
      end
    end else wcnt = 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  // One poll run with checks on ordering, completion and result
  task automatic run_case(input string req, input bit cls, input int nbusy,
                          input logic [7:0] fin, input int l, input int lim,
                          input int exp_res, input bit exp_to, input bit poke);
    int cyc = 0, dones = 0;
    logic [1:0] res_seen = '0;
    logic to_seen = 1'b0;
    bit got = 0;
    @(negedge clk);
    lat = l; bsy_left = nbusy; fin_stat = fin;
    alt_before = 0; stat_reads = 0; seen_stat = 0;
    timeout_lim_i = 16'(lim);
    classify_i = cls; start_i = 1'b1;
    while (!got && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 3) begin start_i = 1'b1; classify_i = ~cls; end
      else start_i = 1'b0;
      if (done_o) begin dones++; got = 1; res_seen = result_o; to_seen = timeout_o; end
    end
    start_i = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (done_o) dones++;
      chk(result_o == res_seen && timeout_o == to_seen, "R10",
          {req, " held result"}, int'(result_o), int'(res_seen));
    end
    chk(dones == 1, "R10", {req, " done pulses"}, dones, 1);
    chk(int'(res_seen) == exp_res, req, "result", int'(res_seen), exp_res);
    chk(to_seen == exp_to, "R8", {req, " timeout flag"}, int'(to_seen), int'(exp_to));
    if (!exp_to) begin
      chk(alt_before == 4, "R1", {req, " settle reads"}, alt_before, 4);
      chk(stat_reads == nbusy + 1, "R2", {req, " status reads"}, stat_reads, nbusy + 1);
    end
    chk(busy_o == 1'b0, "R9", {req, " idle after"}, int'(busy_o), 0);
  endtask

  task automatic test_reset();
    chk(busy_o == 0 && done_o == 0 && rd_req_o == 0, "R11", "ctl after reset",
        int'({busy_o, done_o, rd_req_o}), 0);
    chk(timeout_o == 0 && result_o == 0, "R11", "flags after reset",
        int'({timeout_o, result_o}), 0);
  endtask

  task automatic test_timeout();
    // device stays busy: limit ends the run
    run_case("R8", 1'b1, 100000, 8'h08, 1, 40, 0, 1'b1, 1'b0);
    // limit 0 disables: a long busy wait completes normally
    run_case("R8", 1'b1, 60, 8'h08, 0, 0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_case("R3", 1'b1, 2, 8'h29, 0, 0, 2, 1'b0, 1'b0);
    run_case("R4", 1'b1, 0, 8'h28, 2, 0, 1, 1'b0, 1'b0);
    run_case("R5", 1'b1, 5, 8'h40, 1, 0, 3, 1'b0, 1'b0);
    run_case("R5", 1'b1, 3, 8'h48, 3, 500, 0, 1'b0, 1'b0);
    run_case("R6", 1'b0, 1, 8'h21, 0, 0, 0, 1'b0, 1'b0);
    run_case("R2", 1'b1, 9, 8'h01, 0, 0, 2, 1'b0, 1'b0);
    // R9: second start mid-run with classification flipped is ignored
    run_case("R9", 1'b1, 2, 8'h01, 2, 0, 2, 1'b0, 1'b1);
    test_timeout();
    // R8: normal completion after a timeout clears the flag
    run_case("R8", 1'b1, 1, 8'h20, 0, 100, 1, 1'b0, 1'b0);
    finish_run();
  end

endmodule